// File: doc/BRIEF.md
# SCSI Bus Controller Register Bank

This block is the host-facing register file of a small SCSI protocol controller. A host reaches it with byte reads and writes over a 3-bit offset. Most offsets mean one thing on a read and another on a write. The registers drive the SCSI control and data lines. The live bus lines are sampled back into status bytes. The block also works out whether the bus phase matches the programmed phase, records parity and busy-loss errors, and raises one sticky interrupt line.

An external arbitration sequencer and an external DMA handshake engine sit beside the block. The arbitration sequencer supplies the arbitration-active and arbitration-lost indications. The DMA engine supplies DRQ, end-of-DMA and last-byte-sent, and it receives one-cycle start pulses from this block. While DMA mode is on, the block captures inbound bytes on the falling edge of the handshake line. It uses REQ as initiator and ACK as target.

Top module: `scsi_regbank`

## Requirements
- R1: After reset, every stored register, error flag and interrupt is zero. All bus drive outputs, the data output enable and the DMA start pulses are low.
- R2: Offset 1 command byte. Bits 7 and 4..0 read back as written. Bit 7 = RST, bit 4 = ACK, bit 3 = BSY, bit 2 = SEL, bit 1 = ATN, bit 0 = data drive. On a read, bit 6 shows the arbitration-active input and bit 5 shows the arbitration-lost input. On a write, bit 6 is the tri-state control and bit 5 is ignored.
- R3: Offset 2 (mode) reads back all 8 bits. Its bits are: 7 block DMA, 6 target, 5 parity check, 4 parity interrupt, 3 end-of-DMA interrupt, 2 busy monitor, 1 DMA mode, 0 arbitrate. Offset 3 reads back bits 3..0 (REQ, MSG, CD, IO), bits 6..4 as 0, and bit 7 as the last-byte-sent input.
- R4: Offset 0 reads the live bus data. Offset 4 reads the live lines as {RST,BSY,REQ,MSG,CD,IO,SEL,DBP}, active high.
- R5: The command byte drives RST, BSY, SEL and ATN. It drives ACK only when target mode is off. The target command drives REQ, MSG, CD and IO only when target mode is on. A stored tri-state bit forces every line drive and the data output enable low.
- R6: Phase match (offset 5 bit 3) is 1 exactly when the bus {MSG,CD,IO} equals target command bits 2..0. The codes are data-out 000, data-in 001, command 010, status 011, message-out 110, message-in 111.
- R7: The data output always carries the offset-0 written byte. Its enable is high when arbitration is active, or when command bit 0 is set and the phase matches, provided tri-state is clear.
- R8: With DMA mode on, the bus data is captured into offset 6 in the cycle after a 1-to-0 transition of REQ (initiator) or ACK (target). Nothing is captured with DMA mode off, or on the other handshake line.
- R9: When parity check is enabled, a captured byte whose 8 data bits plus DBP hold an even number of ones sets the parity-error flag (offset 5 bit 5). It also raises the interrupt if parity interrupt is enabled.
- R10: The interrupt is raised while BSY is low, SEL is high, and a data line whose select-enable bit (offset 4 write) is set is asserted.
- R11: A BSY 1-to-0 transition with busy monitor enabled sets busy error (offset 5 bit 2) and the interrupt. An end-of-DMA pulse sets offset 5 bit 7, which a mode write with bit 1 clear removes. The pulse also raises the interrupt if end-of-DMA interrupt is enabled.
- R12: With DMA mode on and no phase match, the interrupt is raised.
- R13: The interrupt (output and offset 5 bit 4) stays set until a read of offset 7. That read clears the interrupt, parity error and busy error, and it wins over a new event in the same cycle.
- R14: A write of any value to offset 5, 6 or 7 pulses exactly one of send, target-receive or initiator-receive for the one cycle after the write, and leaves stored registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe (side effects only) |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte for current offset |
| busDataIn | input | 8 | Live data lines |
| busParityIn | input | 1 | Live data parity line |
| busRstIn | input | 1 | Live RST |
| busBsyIn | input | 1 | Live BSY |
| busReqIn | input | 1 | Live REQ |
| busMsgIn | input | 1 | Live MSG |
| busCdIn | input | 1 | Live CD |
| busIoIn | input | 1 | Live IO |
| busSelIn | input | 1 | Live SEL |
| busAtnIn | input | 1 | Live ATN |
| busAckIn | input | 1 | Live ACK |
| arbActiveIn | input | 1 | Arbitration in progress |
| arbLostIn | input | 1 | Arbitration lost |
| drqIn | input | 1 | DMA request level from DMA engine |
| eodIn | input | 1 | End-of-DMA pulse |
| lastByteSentIn | input | 1 | Last byte sent indication |
| busDataOut | output | 8 | Data to drive on the bus |
| busDataOe | output | 1 | Data drive enable |
| rstOut | output | 1 | Drive RST |
| bsyOut | output | 1 | Drive BSY |
| selOut | output | 1 | Drive SEL |
| atnOut | output | 1 | Drive ATN |
| ackOut | output | 1 | Drive ACK |
| reqOut | output | 1 | Drive REQ |
| msgOut | output | 1 | Drive MSG |
| cdOut | output | 1 | Drive CD |
| ioOut | output | 1 | Drive IO |
| irqOut | output | 1 | Sticky interrupt |
| dmaSendStb | output | 1 | Start DMA send pulse |
| dmaTgtRecvStb | output | 1 | Start target-mode DMA receive pulse |
| dmaIniRecvStb | output | 1 | Start initiator-mode DMA receive pulse |

## Verification
The assertions assume that the host never raises wrEn and rdEn in the same cycle. They also assume that the bus lines and the end-of-DMA pulse change only between clock edges, so each edge sees one settled value. The bench drives every input on the falling clock edge, keeps the two host strobes apart, and issues each access as one-cycle pulses. Bus lines are returned to idle between scenarios, so leftover handshake edges cannot trigger captures or interrupts. Sweeps cover all 256 command bytes, all 256 line patterns, and all 64 pairs of programmed and live phase.

// File: rtl/scsi_regbank_pkg.sv
package scsi_regbank_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;
  localparam int PHASE_W = 3;

  localparam logic [OFF_W-1:0] OFF_DATA   = 3'd0;
  localparam logic [OFF_W-1:0] OFF_ICMD   = 3'd1;
  localparam logic [OFF_W-1:0] OFF_MODE   = 3'd2;
  localparam logic [OFF_W-1:0] OFF_TCMD   = 3'd3;
  localparam logic [OFF_W-1:0] OFF_STAT   = 3'd4;
  localparam logic [OFF_W-1:0] OFF_BSTAT  = 3'd5;
  localparam logic [OFF_W-1:0] OFF_INDATA = 3'd6;
  localparam logic [OFF_W-1:0] OFF_CLEAR  = 3'd7;

  // mode bit positions
  localparam int MD_BLOCK  = 7;
  localparam int MD_TARGET = 6;
  localparam int MD_PCHK   = 5;
  localparam int MD_PINT   = 4;
  localparam int MD_EODINT = 3;
  localparam int MD_BSYMON = 2;
  localparam int MD_DMA    = 1;
  localparam int MD_ARB    = 0;

  // command byte storage mask (bits 6,5 are not stored as command bits)
  localparam logic [BYTE_W-1:0] ICMD_KEEP = 8'h9F;

  typedef struct packed {
    logic wrOut;
    logic wrIcmd;
    logic wrMode;
    logic wrTcmd;
    logic wrSelEn;
    logic rdClear;
  } regStrobeT;
endpackage

// File: rtl/scsi_reg_ctrl.sv
module scsi_reg_ctrl
  import scsi_regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OFF_W-1:0] addr,
  input  logic             wrEn,
  input  logic             rdEn,
  output regStrobeT        stb,
  output logic             dmaSendStb,
  output logic             dmaTgtRecvStb,
  output logic             dmaIniRecvStb
);
  localparam int NUM_OFF = 1 << OFF_W;

  logic [NUM_OFF-1:0] wrHit;
  logic [NUM_OFF-1:0] rdHit;

  genvar g;
  generate
    for (g = 0; g < NUM_OFF; g++) begin : g_dec
      assign wrHit[g] = wrEn && (addr == OFF_W'(g));
      assign rdHit[g] = rdEn && (addr == OFF_W'(g));
    end
  endgenerate

  always_comb begin
    stb.wrOut   = wrHit[OFF_DATA];
    stb.wrIcmd  = wrHit[OFF_ICMD];
    stb.wrMode  = wrHit[OFF_MODE];
    stb.wrTcmd  = wrHit[OFF_TCMD];
    stb.wrSelEn = wrHit[OFF_STAT];
    stb.rdClear = rdHit[OFF_CLEAR];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaSendStb    <= 1'b0;
      dmaTgtRecvStb <= 1'b0;
      dmaIniRecvStb <= 1'b0;
    end else begin
      dmaSendStb    <= wrHit[OFF_BSTAT];
      dmaTgtRecvStb <= wrHit[OFF_INDATA];
      dmaIniRecvStb <= wrHit[OFF_CLEAR];
    end
  end

  // R14
  // Spans the clock edge: write accepted in one cycle, pulse seen in the next.
  send_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_BSTAT) |=> dmaSendStb);

  // R14
  // Outputs only: at most one start pulse at a time.
  one_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmaSendStb, dmaTgtRecvStb, dmaIniRecvStb}));

  // R14
  // Spans the clock edge: no write in one cycle means no pulse in the next.
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !(dmaSendStb || dmaTgtRecvStb || dmaIniRecvStb));
endmodule

// File: rtl/scsi_reg_dpath.sv
module scsi_reg_dpath
  import scsi_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobeT         stb,
  input  logic [OFF_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic [BYTE_W-1:0] busDataIn,
  input  logic              busParityIn,
  input  logic              busRstIn,
  input  logic              busBsyIn,
  input  logic              busReqIn,
  input  logic              busMsgIn,
  input  logic              busCdIn,
  input  logic              busIoIn,
  input  logic              busSelIn,
  input  logic              busAtnIn,
  input  logic              busAckIn,
  input  logic              arbActiveIn,
  input  logic              arbLostIn,
  input  logic              drqIn,
  input  logic              eodIn,
  input  logic              lastByteSentIn,
  output logic [BYTE_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              rstOut,
  output logic              bsyOut,
  output logic              selOut,
  output logic              atnOut,
  output logic              ackOut,
  output logic              reqOut,
  output logic              msgOut,
  output logic              cdOut,
  output logic              ioOut,
  output logic              irqOut
);
  localparam int TCMD_W = PHASE_W + 1;

  logic [BYTE_W-1:0] outReg;
  logic [BYTE_W-1:0] icmdReg;
  logic              triState;
  logic [BYTE_W-1:0] modeReg;
  logic [TCMD_W-1:0] tcmdReg;
  logic [BYTE_W-1:0] selEnReg;
  logic [BYTE_W-1:0] inReg;
  logic              parErr;
  logic              busyErr;
  logic              eodFlag;
  logic              irqFlag;
  logic              prevReq;
  logic              prevAck;
  logic              prevBsy;

  logic [PHASE_W-1:0] busPhase;
  logic               phaseMatch;
  logic               latchEvt;
  logic               parityBad;
  logic               parEvt;
  logic               busyEvt;
  logic               selEvt;
  logic               mismatchEvt;
  logic               irqSrc;
  logic               targetMode;
  logic               dmaMode;

  assign targetMode = modeReg[MD_TARGET];
  assign dmaMode    = modeReg[MD_DMA];
  assign busPhase   = {busMsgIn, busCdIn, busIoIn};
  assign phaseMatch = (busPhase == tcmdReg[PHASE_W-1:0]);

  // handshake edge capture
  assign latchEvt  = dmaMode && (targetMode ? (prevAck && !busAckIn)
                                            : (prevReq && !busReqIn));
  assign parityBad = ~^{busDataIn, busParityIn};
  assign parEvt    = latchEvt && modeReg[MD_PCHK] && parityBad;
  assign busyEvt   = modeReg[MD_BSYMON] && prevBsy && !busBsyIn;
  assign selEvt    = !busBsyIn && busSelIn && |(selEnReg & busDataIn);
  assign mismatchEvt = dmaMode && !phaseMatch;
  assign irqSrc    = selEvt
                   | (parEvt && modeReg[MD_PINT])
                   | (eodIn && modeReg[MD_EODINT])
                   | busyEvt
                   | mismatchEvt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg   <= '0;
      icmdReg  <= '0;
      triState <= 1'b0;
      modeReg  <= '0;
      tcmdReg  <= '0;
      selEnReg <= '0;
      inReg    <= '0;
      parErr   <= 1'b0;
      busyErr  <= 1'b0;
      eodFlag  <= 1'b0;
      irqFlag  <= 1'b0;
      prevReq  <= 1'b0;
      prevAck  <= 1'b0;
      prevBsy  <= 1'b0;
    end else begin
      prevReq <= busReqIn;
      prevAck <= busAckIn;
      prevBsy <= busBsyIn;
      if (stb.wrOut)   outReg <= wrData;
      if (stb.wrIcmd) begin
        icmdReg  <= wrData & ICMD_KEEP;
        triState <= wrData[6];
      end
      if (stb.wrMode)  modeReg  <= wrData;
      if (stb.wrTcmd)  tcmdReg  <= wrData[TCMD_W-1:0];
      if (stb.wrSelEn) selEnReg <= wrData;
      if (latchEvt)    inReg    <= busDataIn;

      if (stb.wrMode && !wrData[MD_DMA]) eodFlag <= 1'b0;
      else if (eodIn)                    eodFlag <= 1'b1;

      if (stb.rdClear) begin
        parErr  <= 1'b0;
        busyErr <= 1'b0;
        irqFlag <= 1'b0;
      end else begin
        if (parEvt)  parErr  <= 1'b1;
        if (busyEvt) busyErr <= 1'b1;
        if (irqSrc)  irqFlag <= 1'b1;
      end
    end
  end

  // line drives
  always_comb begin
    rstOut = !triState && icmdReg[7];
    ackOut = !triState && icmdReg[4] && !targetMode;
    bsyOut = !triState && icmdReg[3];
    selOut = !triState && icmdReg[2];
    atnOut = !triState && icmdReg[1];
    reqOut = !triState && targetMode && tcmdReg[3];
    msgOut = !triState && targetMode && tcmdReg[2];
    cdOut  = !triState && targetMode && tcmdReg[1];
    ioOut  = !triState && targetMode && tcmdReg[0];
    busDataOut = outReg;
    busDataOe  = !triState && (arbActiveIn || (icmdReg[0] && phaseMatch));
    irqOut     = irqFlag;
  end

  // read mux
  always_comb begin
    unique case (addr)
      OFF_DATA:   rdData = busDataIn;
      OFF_ICMD:   rdData = icmdReg | {1'b0, arbActiveIn, arbLostIn, 5'b0};
      OFF_MODE:   rdData = modeReg;
      OFF_TCMD:   rdData = {lastByteSentIn, {(BYTE_W-1-TCMD_W){1'b0}}, tcmdReg};
      OFF_STAT:   rdData = {busRstIn, busBsyIn, busReqIn, busMsgIn,
                            busCdIn, busIoIn, busSelIn, busParityIn};
      OFF_BSTAT:  rdData = {eodFlag, drqIn, parErr, irqFlag,
                            phaseMatch, busyErr, busAtnIn, busAckIn};
      OFF_INDATA: rdData = inReg;
      default:    rdData = '0;
    endcase
  end

  // R13
  // Clear priority: register state after the offset-7 read.
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdClear |=> (!irqFlag && !parErr && !busyErr));

  // R13
  // Sticky: once set, the interrupt survives any cycle without a clear read.
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !stb.rdClear) |=> irqFlag);

  // R8
  // Capture register holds while DMA mode is off.
  no_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dmaMode |=> $stable(inReg));

  // R11
  // Bus BSY falling with the monitor on reaches the interrupt in the next cycle.
  busy_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[MD_BSYMON] && prevBsy && !busBsyIn && !stb.rdClear) |=> irqFlag);

  // R9
  // Parity error holds until the clear read.
  parity_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (parErr && !stb.rdClear) |=> parErr);
endmodule

// File: rtl/scsi_regbank.sv
module scsi_regbank
  import scsi_regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] addr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [7:0] busDataIn,
  input  logic       busParityIn,
  input  logic       busRstIn,
  input  logic       busBsyIn,
  input  logic       busReqIn,
  input  logic       busMsgIn,
  input  logic       busCdIn,
  input  logic       busIoIn,
  input  logic       busSelIn,
  input  logic       busAtnIn,
  input  logic       busAckIn,
  input  logic       arbActiveIn,
  input  logic       arbLostIn,
  input  logic       drqIn,
  input  logic       eodIn,
  input  logic       lastByteSentIn,
  output logic [7:0] busDataOut,
  output logic       busDataOe,
  output logic       rstOut,
  output logic       bsyOut,
  output logic       selOut,
  output logic       atnOut,
  output logic       ackOut,
  output logic       reqOut,
  output logic       msgOut,
  output logic       cdOut,
  output logic       ioOut,
  output logic       irqOut,
  output logic       dmaSendStb,
  output logic       dmaTgtRecvStb,
  output logic       dmaIniRecvStb
);
  regStrobeT stb;

  scsi_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .stb(stb), .dmaSendStb(dmaSendStb), .dmaTgtRecvStb(dmaTgtRecvStb),
    .dmaIniRecvStb(dmaIniRecvStb)
  );

  scsi_reg_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .busDataIn(busDataIn), .busParityIn(busParityIn),
    .busRstIn(busRstIn), .busBsyIn(busBsyIn), .busReqIn(busReqIn),
    .busMsgIn(busMsgIn), .busCdIn(busCdIn), .busIoIn(busIoIn),
    .busSelIn(busSelIn), .busAtnIn(busAtnIn), .busAckIn(busAckIn),
    .arbActiveIn(arbActiveIn), .arbLostIn(arbLostIn), .drqIn(drqIn),
    .eodIn(eodIn), .lastByteSentIn(lastByteSentIn),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .rstOut(rstOut),
    .bsyOut(bsyOut), .selOut(selOut), .atnOut(atnOut), .ackOut(ackOut),
    .reqOut(reqOut), .msgOut(msgOut), .cdOut(cdOut), .ioOut(ioOut),
    .irqOut(irqOut)
  );
endmodule

// File: tb/scsi_regbank_tb.sv
module scsi_regbank_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] busDataIn = '0;
  logic busParityIn = 0, busRstIn = 0, busBsyIn = 0, busReqIn = 0;
  logic busMsgIn = 0, busCdIn = 0, busIoIn = 0, busSelIn = 0;
  logic busAtnIn = 0, busAckIn = 0, arbActiveIn = 0, arbLostIn = 0;
  logic drqIn = 0, eodIn = 0, lastByteSentIn = 0;
  logic [7:0] busDataOut;
  logic busDataOe, rstOut, bsyOut, selOut, atnOut, ackOut;
  logic reqOut, msgOut, cdOut, ioOut, irqOut;
  logic dmaSendStb, dmaTgtRecvStb, dmaIniRecvStb;

  int testCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  scsi_regbank u_dut (.*);

  task automatic check(input string tag, input int got, input int exp);
    testCnt++;
    if (got != exp) begin
      failCnt++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdClr();
    @(negedge clk); addr = 3'd7; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failCnt++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [7:0] v;
    step(3);
    rstN = 1'b1;
    step(1);

    // R1 reset state
    peek(3'd1, v); check("R1 cmd", v, 0);
    peek(3'd2, v); check("R1 mode", v, 0);
    peek(3'd6, v); check("R1 indata", v, 0);
    check("R1 drives", {rstOut,bsyOut,selOut,atnOut,ackOut,reqOut,msgOut,cdOut,ioOut,irqOut,
                        dmaSendStb,dmaTgtRecvStb,dmaIniRecvStb}, 0);
    peek(3'd5, v); check("R1 bstat", v, 8'h08);

    // R2 sweep of all command bytes, arbitration inputs low
    for (int k = 0; k < 256; k++) begin
      wr(3'd1, 8'(k));
      peek(3'd1, v); check("R2 sweep", v, k & 8'h9F);
    end
    arbActiveIn = 1; arbLostIn = 1;
    wr(3'd1, 8'h00);
    peek(3'd1, v); check("R2 arb bits", v, 8'h60);
    arbActiveIn = 0; arbLostIn = 0;

    // R3 mode / target command readback
    wr(3'd2, 8'hA5); peek(3'd2, v); check("R3 mode", v, 8'hA5);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'hFF); lastByteSentIn = 1; peek(3'd3, v); check("R3 tcmd", v, 8'h8F);
    lastByteSentIn = 0; wr(3'd3, 8'h00);

    // R4 live lines sweep
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      {busRstIn,busBsyIn,busReqIn,busMsgIn,busCdIn,busIoIn,busSelIn,busParityIn} = 8'(k);
      busDataIn = 8'(k) ^ 8'h5A;
      peek(3'd4, v); check("R4 stat", v, k);
      peek(3'd0, v); check("R4 data", v, (k ^ 8'h5A) & 8'hFF);
    end
    @(negedge clk);
    {busRstIn,busBsyIn,busReqIn,busMsgIn,busCdIn,busIoIn,busSelIn,busParityIn} = 8'h00;
    busDataIn = 8'h00;
    step(2); rdClr();

    // R6 phase match sweep
    for (int t = 0; t < 8; t++) begin
      wr(3'd3, 8'(t));
      for (int b = 0; b < 8; b++) begin
        {busMsgIn, busCdIn, busIoIn} = 3'(b);
        peek(3'd5, v); check("R6 match", v, (t == b) ? 8'h08 : 8'h00);
        @(negedge clk);
      end
    end
    {busMsgIn, busCdIn, busIoIn} = 3'b000;
    wr(3'd3, 8'h00);

    // R5 line drives
    wr(3'd1, 8'h9E); #1;
    check("R5 ini drives", {rstOut,bsyOut,selOut,atnOut,ackOut}, 5'b11111);
    wr(3'd3, 8'h0F); #1;
    check("R5 ini no tgt", {reqOut,msgOut,cdOut,ioOut}, 0);
    wr(3'd2, 8'h40); #1;
    check("R5 tgt drives", {reqOut,msgOut,cdOut,ioOut,ackOut}, 5'b11110);
    wr(3'd1, 8'hDE); #1;
    check("R5 tristate", {rstOut,bsyOut,selOut,atnOut,ackOut,reqOut,msgOut,cdOut,ioOut}, 0);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);

    // R7 data drive
    wr(3'd0, 8'h3C); wr(3'd1, 8'h01); #1;
    check("R7 oe match", {busDataOe, busDataOut}, {1'b1, 8'h3C});
    busIoIn = 1; #1;
    check("R7 oe mismatch", busDataOe, 0);
    arbActiveIn = 1; #1;
    check("R7 oe arb", busDataOe, 1);
    wr(3'd1, 8'h41); #1;
    check("R7 oe tristate", busDataOe, 0);
    arbActiveIn = 0; busIoIn = 0;
    wr(3'd1, 8'h00);

    // R8 capture: DMA off -> none
    busDataIn = 8'hA5; busParityIn = 1;
    busReqIn = 1; step(1); busReqIn = 0; step(2);
    peek(3'd6, v); check("R8 no dma", v, 0);
    wr(3'd2, 8'h02);
    busReqIn = 1; step(1); busReqIn = 0; step(1);
    peek(3'd6, v); check("R8 req fall", v, 8'hA5);
    busDataIn = 8'h11;
    busAckIn = 1; step(1); busAckIn = 0; step(1);
    peek(3'd6, v); check("R8 ini ignores ack", v, 8'hA5);
    wr(3'd2, 8'h42);
    busDataIn = 8'h77; busParityIn = 0;
    busAckIn = 1; step(1); busAckIn = 0; step(1);
    peek(3'd6, v); check("R8 ack fall", v, 8'h77);

    // R9 parity error
    wr(3'd2, 8'h32);
    busDataIn = 8'hA5; busParityIn = 0;
    busReqIn = 1; step(1); busReqIn = 0; step(1);
    peek(3'd5, v); check("R9 parity err", v, 8'h38);
    // R13 clear
    rdClr(); peek(3'd5, v); check("R13 clear", v, 8'h08);
    wr(3'd2, 8'h00); busDataIn = 0; busParityIn = 0;

    // R10 selection
    wr(3'd4, 8'h04);
    busSelIn = 1; busDataIn = 8'h02; step(2);
    check("R10 other id", irqOut, 0);
    busDataIn = 8'h04; step(1);
    check("R10 sel irq", irqOut, 1);
    busSelIn = 0; busDataIn = 0; step(2);
    check("R13 sticky", irqOut, 1);
    rdClr(); check("R13 cleared", irqOut, 0);

    // R11 busy loss
    wr(3'd2, 8'h04);
    busBsyIn = 1; step(1); busBsyIn = 0; step(1);
    peek(3'd5, v); check("R11 busy err", v, 8'h1C);
    rdClr(); peek(3'd5, v); check("R11 busy cleared", v, 8'h08);

    // R11 end of DMA
    wr(3'd2, 8'h0A);
    eodIn = 1; step(1); eodIn = 0; step(1);
    peek(3'd5, v); check("R11 eod", v, 8'h98);
    wr(3'd2, 8'h00); rdClr();
    peek(3'd5, v); check("R11 eod cleared", v, 8'h08);

    // R12 mismatch in DMA
    wr(3'd3, 8'h01); step(2);
    check("R12 no dma", irqOut, 0);
    wr(3'd2, 8'h02); step(1);
    check("R12 mismatch irq", irqOut, 1);
    wr(3'd3, 8'h00); rdClr(); step(1);
    check("R12 matched", irqOut, 0);
    wr(3'd2, 8'h00);

    // R14 start pulses
    wr(3'd5, 8'h00);
    check("R14 send", {dmaSendStb,dmaTgtRecvStb,dmaIniRecvStb}, 3'b100);
    step(1); check("R14 one cycle", {dmaSendStb,dmaTgtRecvStb,dmaIniRecvStb}, 0);
    wr(3'd6, 8'hFF);
    check("R14 tgt recv", {dmaSendStb,dmaTgtRecvStb,dmaIniRecvStb}, 3'b010);
    wr(3'd7, 8'h5A);
    check("R14 ini recv", {dmaSendStb,dmaTgtRecvStb,dmaIniRecvStb}, 3'b001);
    peek(3'd2, v); check("R14 mode untouched", v, 0);
    peek(3'd6, v); check("R14 indata untouched", v, 8'hA5);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule